// File: doc/BRIEF.md
# Packet receive FIFO with overflow policy

This block is the receive-side byte store between an HDLC deframer and a host. Each byte is stored with three tags: packet start, packet end and abort. The write side offers one byte per cycle with its start and end flags. The read side is a show-ahead byte port: the head entry is always visible, and a read request removes it.

When the store is full, the block does not stall the writer. A byte that cannot be stored is dropped and a sticky overflow flag is raised. If a packet was open, its last stored byte is tagged as both end and abort, so the host sees a closed but damaged packet. The block then discards every incoming byte until a packet-start byte arrives while there is room.

A live data-available flag compares the fill level with a host-programmed watermark. It can also drive an interrupt request.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset the block is empty. The level is 0, rd_empty_o is 1, and avail_o, irq_o and ovf_o are 0.
- R2: Stored bytes come out in write order with their start and end tags. level_o counts the stored entries, and the store holds DEPTH (256) entries. A read request while not empty removes the head, which is shown on rd_data_o, rd_sop_o, rd_eop_o and rd_abort_o.
- R3: A read request while empty leaves the level unchanged. While empty, all read-side data and tag outputs are 0.
- R4: avail_o is 1 exactly while level_o is strictly greater than wm_level_i. It is not latched.
- R5: irq_o equals avail_o when irq_en_i is 1, and is 0 when irq_en_i is 0.
- R6: A packet-start byte offered while full is not stored. ovf_o is 1 from the next cycle.
- R7: Any byte offered while full while a packet is open sets both the end and abort tags on the last stored byte, closes the packet, and sets ovf_o. No entry is added.
- R8: After an overflow, every byte is discarded, including non-start bytes offered with room. The first packet-start byte offered with room is stored and ends the discard state.
- R9: ovf_o is sticky and is cleared by a one-cycle pulse on ovf_clr_i. A new overflow event in the same cycle as the pulse wins, and ovf_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte offered this cycle |
| wr_data_i | input | 8 | Write byte |
| wr_sop_i | input | 1 | Byte starts a packet |
| wr_eop_i | input | 1 | Byte ends a packet |
| rd_req_i | input | 1 | Remove head entry |
| rd_data_o | output | 8 | Head byte (0 when empty) |
| rd_sop_o | output | 1 | Head start tag |
| rd_eop_o | output | 1 | Head end tag |
| rd_abort_o | output | 1 | Head abort tag |
| rd_empty_o | output | 1 | Store empty |
| level_o | output | 9 | Stored entry count |
| wm_level_i | input | 9 | Data-available watermark |
| irq_en_i | input | 1 | Interrupt enable |
| avail_o | output | 1 | Level above watermark |
| irq_o | output | 1 | Interrupt request |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clear pulse for ovf_o |

## Verification
The hardest state to reach is the discard window after an overflow when room has reappeared. In that window a non-start byte must still be dropped, and only a start byte may resume storage. The stimulus fills all 256 entries with one unterminated packet, then offers bytes while full: first a continuation byte, then a start byte, then a byte coinciding with a clear pulse. It then reads two entries and offers a continuation byte followed by a start byte. A final full drain lets the scoreboard confirm that the truncated packet's last byte carries both the end and abort tags.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              abort;
    logic              eop;
    logic              sop;
    logic [DATA_W-1:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  fifo_ent_t     push_ent_i,
  input  logic          pop_i,
  input  logic          mark_i,
  output fifo_ent_t     head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  fifo_ent_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, last_ptr;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o   = (count_q == CW'(DEPTH));
  assign empty_o  = (count_q == '0);
  assign do_push  = push_i && !full_o;
  assign do_pop   = pop_i && !empty_o;
  assign last_ptr = wr_ptr_q - 1'b1;
  assign count_o  = count_q;
  assign head_o   = empty_o ? '0 : mem[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= push_ent_i;
    // truncate open packet: close it on its last stored byte
    if (mark_i) begin
      mem[last_ptr].eop   <= 1'b1;
      mem[last_ptr].abort <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  a_r2_push_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  a_r3_empty_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (count_o == '0) && $stable(rd_ptr_q));
  a_r7_mark_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i |-> full_o);
endmodule

// File: rtl/pkt_ovf_ctrl.sv
module pkt_ovf_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_valid_i,
  input  logic wr_sop_i,
  input  logic wr_eop_i,
  input  logic full_i,
  output logic push_o,
  output logic mark_o,
  output logic ovf_evt_o
);
  logic drop_q;  // discarding until a start byte finds room
  logic open_q;  // a stored packet has no end yet

  always_comb begin
    push_o    = 1'b0;
    mark_o    = 1'b0;
    ovf_evt_o = 1'b0;
    if (wr_valid_i) begin
      if (full_i) begin
        ovf_evt_o = 1'b1;
        mark_o    = open_q;
      end else if (!drop_q || wr_sop_i) begin
        push_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_q <= 1'b0;
      open_q <= 1'b0;
    end else if (ovf_evt_o) begin
      drop_q <= 1'b1;
      if (mark_o) open_q <= 1'b0;
    end else if (push_o) begin
      drop_q <= 1'b0;
      if (wr_eop_i)      open_q <= 1'b0;
      else if (wr_sop_i) open_q <= 1'b1;
    end
  end

  a_r8_drop_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_q && wr_valid_i && !wr_sop_i) |-> !push_o);
  a_r6_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full_i) |-> (!push_o && ovf_evt_o));
  a_r8_resync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && wr_sop_i) |=> !drop_q);
endmodule

// File: rtl/pkt_fifo_stat.sv
module pkt_fifo_stat #(
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] level_i,
  input  logic [CW-1:0] wm_i,
  input  logic          irq_en_i,
  input  logic          ovf_set_i,
  input  logic          ovf_clr_i,
  output logic          avail_o,
  output logic          irq_o,
  output logic          ovf_o
);
  logic ovf_q;

  assign avail_o = (level_i > wm_i);
  assign irq_o   = irq_en_i && avail_o;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_set_i) ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  a_r9_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_o);
  a_r9_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_set_i && !ovf_clr_i) |=> (ovf_o == $past(ovf_o)));
  a_r9_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !ovf_set_i) |=> !ovf_o);
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_sop_i,
  input  logic              wr_eop_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sop_o,
  output logic              rd_eop_o,
  output logic              rd_abort_o,
  output logic              rd_empty_o,
  output logic [CW-1:0]     level_o,
  input  logic [CW-1:0]     wm_level_i,
  input  logic              irq_en_i,
  output logic              avail_o,
  output logic              irq_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  fifo_ent_t     push_ent, head;
  logic          push, mark, ovf_evt, full;
  logic [CW-1:0] count;

  assign push_ent = '{abort: 1'b0, eop: wr_eop_i, sop: wr_sop_i, data: wr_data_i};

  pkt_ovf_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_sop_i   (wr_sop_i),
    .wr_eop_i   (wr_eop_i),
    .full_i     (full),
    .push_o     (push),
    .mark_o     (mark),
    .ovf_evt_o  (ovf_evt)
  );

  pkt_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_ent_i (push_ent),
    .pop_i      (rd_req_i),
    .mark_i     (mark),
    .head_o     (head),
    .count_o    (count),
    .full_o     (full),
    .empty_o    (rd_empty_o)
  );

  pkt_fifo_stat #(.CW(CW)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (count),
    .wm_i      (wm_level_i),
    .irq_en_i  (irq_en_i),
    .ovf_set_i (ovf_evt),
    .ovf_clr_i (ovf_clr_i),
    .avail_o   (avail_o),
    .irq_o     (irq_o),
    .ovf_o     (ovf_o)
  );

  assign rd_data_o  = head.data;
  assign rd_sop_o   = head.sop;
  assign rd_eop_o   = head.eop;
  assign rd_abort_o = head.abort;
  assign level_o    = count;

  a_r7_full_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full && !rd_req_i) |=> (level_o == $past(level_o)));
endmodule

// File: tb/tb_pkt_rx_fifo.sv
module tb_pkt_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_req = 1'b0, irq_en = 1'b0, ovf_clr = 1'b0;
  logic [8:0] wm = '0;
  logic [7:0] rd_data;
  logic       rd_sop, rd_eop, rd_abort, rd_empty, avail, irq, ovf;
  logic [8:0] level;

  int checks = 0;
  int errors = 0;

  // expected entry: {abort, eop, sop, data}
  logic [10:0] exp_q[$];
  bit m_open = 0, m_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_rx_fifo #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_sop_i(wr_sop), .wr_eop_i(wr_eop),
    .rd_req_i(rd_req), .rd_data_o(rd_data), .rd_sop_o(rd_sop), .rd_eop_o(rd_eop),
    .rd_abort_o(rd_abort), .rd_empty_o(rd_empty), .level_o(level),
    .wm_level_i(wm), .irq_en_i(irq_en), .avail_o(avail), .irq_o(irq),
    .ovf_o(ovf), .ovf_clr_i(ovf_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compare head against scoreboard on every accepted read
  always @(negedge clk) begin
    if (rst_n && rd_req && !rd_empty) begin
      logic [10:0] act, exp;
      act = {rd_abort, rd_eop, rd_sop, rd_data};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: actual %h expected none", act);
      end else begin
        exp = exp_q.pop_front();
        if (act != exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", exp[10] ? "R7" : "R2", act, exp);
        end
      end
    end
  end

  // driver: one write cycle, scoreboard follows the overflow policy
  task automatic wr(input logic [7:0] d, input bit s, input bit e, input bit clr = 0);
    if (exp_q.size() == DEPTH) begin
      if (m_open) begin
        exp_q[exp_q.size()-1][10] = 1'b1;
        exp_q[exp_q.size()-1][9]  = 1'b1;
        m_open = 0;
      end
      m_drop = 1;
    end else if (!m_drop || s) begin
      exp_q.push_back({1'b0, e, s, d});
      m_drop = 0;
      if (e) m_open = 0;
      else if (s) m_open = 1;
    end
    wr_valid = 1; wr_data = d; wr_sop = s; wr_eop = e; ovf_clr = clr;
    @(posedge clk); #1;
    wr_valid = 0; wr_sop = 0; wr_eop = 0; ovf_clr = 0;
  endtask

  task automatic rd_n(input int n);
    rd_req = 1;
    repeat (n) begin @(posedge clk); #1; end
    rd_req = 0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1; @(posedge clk); #1; ovf_clr = 0;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic realign();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sample();
    chk("R1 level", int'(level), 0);
    chk("R1 empty", int'(rd_empty), 1);
    chk("R1 avail", int'(avail), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ovf", int'(ovf), 0);
    realign();

    // R3: read while empty
    rd_req = 1;
    sample();
    chk("R3 data", int'({rd_abort, rd_eop, rd_sop, rd_data}), 0);
    realign();
    rd_req = 0;
    sample();
    chk("R3 level", int'(level), 0);
    realign();

    // R2 short packet, R4/R5 watermark
    wr(8'h11, 1, 0); wr(8'h22, 0, 0); wr(8'h33, 0, 0); wr(8'h44, 0, 0); wr(8'h55, 0, 1);
    wm = 9'd3; irq_en = 0;
    sample();
    chk("R2 level", int'(level), 5);
    chk("R4 above", int'(avail), 1);
    chk("R5 masked", int'(irq), 0);
    realign();
    irq_en = 1;
    sample();
    chk("R5 enabled", int'(irq), 1);
    realign();
    wm = 9'd5;
    sample();
    chk("R4 equal", int'(avail), 0);
    chk("R5 follows", int'(irq), 0);
    realign();
    wm = 9'd4;
    sample();
    chk("R4 one below", int'(avail), 1);
    realign();
    rd_n(5);
    sample();
    chk("R2 drained", int'(level), 0);
    chk("R4 empty", int'(avail), 0);
    realign();

    // fill with one open packet
    wr(8'h00, 1, 0);
    for (int i = 1; i < DEPTH; i++) wr(8'(i), 0, 0);
    sample();
    chk("R2 full level", int'(level), DEPTH);
    chk("R1 no ovf yet", int'(ovf), 0);
    realign();

    wr(8'hA0, 0, 0);  // R7 truncation
    sample();
    chk("R7 ovf", int'(ovf), 1);
    chk("R7 level", int'(level), DEPTH);
    realign();
    wr(8'hA1, 0, 0);
    sample();
    chk("R8 discard full", int'(level), DEPTH);
    realign();
    clear_ovf();
    sample();
    chk("R9 cleared", int'(ovf), 0);
    realign();
    wr(8'hB0, 1, 0);  // R6 start byte while full
    sample();
    chk("R6 ovf", int'(ovf), 1);
    chk("R6 level", int'(level), DEPTH);
    realign();
    clear_ovf();
    wr(8'hB1, 0, 0, 1);  // R9 set wins over clear
    sample();
    chk("R9 set wins", int'(ovf), 1);
    realign();

    rd_n(2);
    sample();
    chk("R2 after reads", int'(level), DEPTH - 2);
    realign();
    wr(8'hC0, 0, 1);  // R8 non-start with room still discarded
    sample();
    chk("R8 non-start dropped", int'(level), DEPTH - 2);
    realign();
    wr(8'hD0, 1, 0);
    sample();
    chk("R8 resync", int'(level), DEPTH - 1);
    realign();
    wr(8'hD1, 0, 1);
    sample();
    chk("R8 after resync", int'(level), DEPTH);
    realign();

    rd_n(DEPTH);
    sample();
    chk("R2 final level", int'(level), 0);
    chk("R2 scoreboard empty", exp_q.size(), 0);
    chk("R3 empty outputs", int'({rd_abort, rd_eop, rd_sop, rd_data}), 0);
    realign();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule